// File: doc/BRIEF.md
# I2C Register Read Target with Windowed Pointer

This block is an I2C target that gives a master byte-wide read access to a small internal register file. SCL and SDA are brought into the system clock domain through two-flop synchronizers, and bus conditions are found by edge detection on the synchronized lines. The target answers one fixed 7-bit device address. It drives SDA only as an open-drain pull-down enable.

A write transfer carries one byte that sets an internal read pointer. A read transfer then streams bytes from that pointer for as long as the master acknowledges. The pointer is kept between transfers and steps by one for every byte the target loads for sending. It never leaves its current window: the low window covers 0x00 to 0x0C and the high window covers 0x10 to 0x12, and each wraps to its own first address. A side port lets a testbench or neighbouring logic fill the register file.

Top module: `i2c_windowed_reader`

## Requirements
- R1: After reset, sda_oe is 0 and the pointer is 0x00, so the first read with no pointer write returns the contents of register 0x00.
- R2: An address byte whose upper seven bits equal DEV_ADDR (default 0x0C) and whose last bit is 1 is acknowledged: SDA is held low through the ninth SCL pulse.
- R3: An address byte that does not match is not acknowledged, and SDA stays released for every later bit until the next START.
- R4: In a write transfer to the device, the byte after the address is acknowledged. If it lies in 0x00..0x0C or 0x10..0x12, it becomes the pointer, and a repeated START followed by a read returns data from that address.
- R5: A pointer byte outside both windows is still acknowledged but leaves the pointer unchanged.
- R6: Data bytes are sent most significant bit first, and SDA never changes while SCL is high during a data bit.
- R7: The pointer advances by one for each byte the target loads for sending. After a master ACK the next byte follows on the next SCL pulses, with no limit on length.
- R8: Stepping past 0x0C gives 0x00, and stepping past 0x12 gives 0x10.
- R9: The pointer persists across transfers. A read with no pointer write returns the register one beyond the last one sent.
- R10: After a master NACK and a STOP, the read has ended and SDA is released.
- R11: A START (SDA falling while SCL high) or STOP (SDA rising while SCL high) aborts any transfer in progress. After a START, address reception restarts from bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ld_we | input | 1 | Register file load strobe |
| ld_addr | input | AW (5) | Register file load address |
| ld_data | input | 8 | Register file load data |

## Verification
The cases hardest to reach from the pins are the two wrap points and the abort of a half-received address byte. Both depend on the pointer or the bit counter sitting at one particular value when the next event comes. The bench reaches each wrap by writing the pointer to the second-to-last address of a window and then streaming three bytes across the boundary. It reaches the abort by clocking only four address bits before issuing a new START, then checking that a full pointer write and read after that still succeed. Pointer persistence is checked by chaining scenarios: each one starts from the pointer the previous scenario left behind.

// File: rtl/i2c_windowed_reader.sv
module i2c_windowed_reader #(
  parameter logic [6:0] DEV_ADDR = 7'h0C,
  parameter int AW    = 5,
  parameter int W0_LO = 0,
  parameter int W0_HI = 12,
  parameter int W1_LO = 16,
  parameter int W1_HI = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe,
  input  logic          ld_we,
  input  logic [AW-1:0] ld_addr,
  input  logic [7:0]    ld_data
);
  localparam int DEPTH = 1 << AW;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AACK, S_REG, S_RACK, S_TX, S_MACK, S_WAIT
  } state_t;

  logic [7:0] regs [DEPTH];
  logic scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q;
  state_t state;
  logic [2:0] cnt;
  logic [7:0] sh, tx;
  logic [AW-1:0] ptr;
  logic full, rw, mack, oe;

  always_ff @(posedge clk) if (ld_we) regs[ld_addr] <= ld_data;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {scl_s1, scl_s2, scl_q, sda_s1, sda_s2, sda_q} <= 6'b111111;
    else begin
      scl_s1 <= scl_i; scl_s2 <= scl_s1; scl_q <= scl_s2;
      sda_s1 <= sda_i; sda_s2 <= sda_s1; sda_q <= sda_s2;
    end

  wire scl_rise  = scl_s2 & ~scl_q;
  wire scl_fall  = ~scl_s2 & scl_q;
  wire start_det = scl_s2 & scl_q & sda_q & ~sda_s2;
  wire stop_det  = scl_s2 & scl_q & ~sda_q & sda_s2;

  function automatic logic in_win(input logic [7:0] a);
    return (int'(a) >= W0_LO && int'(a) <= W0_HI) ||
           (int'(a) >= W1_LO && int'(a) <= W1_HI);
  endfunction

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    if (p == AW'(W0_HI)) return AW'(W0_LO);
    if (p == AW'(W1_HI)) return AW'(W1_LO);
    return p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; sh <= '0; tx <= '0; ptr <= AW'(W0_LO);
      full <= 1'b0; rw <= 1'b0; mack <= 1'b0; oe <= 1'b0;
    end else if (start_det) begin
      state <= S_ADDR; cnt <= '0; full <= 1'b0; oe <= 1'b0;
    end else if (stop_det) begin
      state <= S_IDLE; cnt <= '0; full <= 1'b0; oe <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_REG: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s2};
            cnt <= cnt + 3'd1;
            if (cnt == 3'd7) full <= 1'b1;
          end else if (scl_fall && full) begin
            full <= 1'b0;
            cnt  <= '0;
            if (state == S_ADDR) begin
              if (sh[7:1] == DEV_ADDR) begin
                oe <= 1'b1; rw <= sh[0]; state <= S_AACK;
              end else state <= S_WAIT;
            end else begin
              oe <= 1'b1;
              state <= S_RACK;
              if (in_win(sh)) ptr <= sh[AW-1:0];
            end
          end
        end
        S_AACK: if (scl_fall) begin
          if (rw) begin
            tx <= regs[ptr]; oe <= ~regs[ptr][7]; ptr <= nxt(ptr); state <= S_TX;
          end else begin
            oe <= 1'b0; state <= S_REG;
          end
        end
        S_RACK: if (scl_fall) begin
          oe <= 1'b0; state <= S_WAIT;
        end
        S_TX: if (scl_fall) begin
          if (cnt == 3'd7) begin
            oe <= 1'b0; cnt <= '0; state <= S_MACK;
          end else begin
            cnt <= cnt + 3'd1; tx <= {tx[6:0], 1'b0}; oe <= ~tx[6];
          end
        end
        S_MACK: begin
          if (scl_rise) mack <= ~sda_s2;
          else if (scl_fall) begin
            if (mack) begin
              tx <= regs[ptr]; oe <= ~regs[ptr][7]; ptr <= nxt(ptr); state <= S_TX;
            end else state <= S_WAIT;
          end
        end
        default: ;
      endcase
    end

  assign sda_oe = oe;

  assert_no_raise_while_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s2 && scl_q) |=> !$rose(sda_oe));
  assert_ptr_in_window_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_win(8'(ptr)));
  assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);
  assert_start_rearms_R11: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_ADDR && cnt == 3'd0 && !sda_oe));
  assert_silent_until_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !start_det) |=> !sda_oe);
endmodule

// File: tb/i2c_windowed_reader_tb.sv
module i2c_windowed_reader_tb;
  localparam int H = 10;
  localparam logic [6:0] DEV = 7'h0C;

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, m_sda = 1'b1;
  logic ld_we = 1'b0;
  logic [4:0] ld_addr = '0;
  logic [7:0] ld_data = '0;
  logic sda_oe;
  wire sda_line = m_sda & ~sda_oe;
  int checks = 0, errors = 0, stab_err = 0;

  always #4 clk = ~clk;

  i2c_windowed_reader u_dut (.clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data));

  function automatic logic [7:0] pat(input int a);
    return 8'(a * 37 + 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wh(input int n = H);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start;
    m_sda = 1'b1; wh(); scl = 1'b1; wh(); m_sda = 1'b0; wh(); scl = 1'b0; wh();
  endtask

  task automatic i2c_stop;
    m_sda = 1'b0; wh(); scl = 1'b1; wh(); m_sda = 1'b1; wh();
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; wh(); scl = 1'b1; wh(); scl = 1'b0;
    end
    m_sda = 1'b1; wh(); scl = 1'b1; wh(H / 2);
    acked = (sda_line == 1'b0);
    wh(H / 2); scl = 1'b0;
  endtask

  task automatic recv_byte(input bit ack_it, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      logic a;
      wh(); scl = 1'b1; wh(2);
      a = sda_line;
      wh(H - 3);
      if (sda_line !== a) stab_err++;
      b[i] = a;
      wh(1); scl = 1'b0;
    end
    m_sda = ack_it ? 1'b0 : 1'b1; wh(); scl = 1'b1; wh(); scl = 1'b0; m_sda = 1'b1;
  endtask

  task automatic read_stream(input int first, input int n, input string req);
    int a = first;
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      recv_byte(k != n - 1, d);
      check(d == pat(a), req, d, pat(a));
      a = (a == 12) ? 0 : (a == 18) ? 16 : a + 1;
    end
  endtask

  task automatic read_from(input logic [7:0] reg_a, input bit exp_load, input int first,
                           input int n, input string req);
    bit ack;
    i2c_start(); send_byte({DEV, 1'b0}, ack);
    check(ack, "R4 write address ack", ack, 1);
    send_byte(reg_a, ack);
    check(ack, exp_load ? "R4 pointer byte ack" : "R5 out-of-window byte ack", ack, 1);
    i2c_start(); send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    read_stream(first, n, req);
    i2c_stop();
  endtask

  task automatic current_read(input int first, input int n, input string req);
    bit ack;
    i2c_start(); send_byte({DEV, 1'b1}, ack);
    check(ack, "R2 read address ack", ack, 1);
    read_stream(first, n, req);
    i2c_stop();
    check(sda_oe == 1'b0 && sda_line == 1'b1, "R10 released after NACK+STOP", sda_oe, 0);
  endtask

  task automatic t_reset;
    check(sda_oe == 1'b0, "R1 sda_oe at reset", sda_oe, 0);
  endtask

  task automatic t_first_read;
    current_read(0, 1, "R1 first read from 0x00");
  endtask

  task automatic t_persist;
    current_read(1, 2, "R9 R7 persisted pointer stream");
  endtask

  task automatic t_wrap_low;
    read_from(8'h0B, 1'b1, 11, 3, "R8 low window wrap");
  endtask

  task automatic t_wrap_high;
    read_from(8'h11, 1'b1, 17, 3, "R8 high window wrap");
    current_read(17, 1, "R9 read after high wrap");
  endtask

  task automatic t_mismatch;
    bit ack;
    logic [7:0] d;
    i2c_start(); send_byte({7'h2A, 1'b1}, ack);
    check(!ack, "R3 no ack on other address", ack, 0);
    recv_byte(1'b0, d);
    check(d == 8'hFF, "R3 line released after mismatch", d, 8'hFF);
    i2c_stop();
  endtask

  task automatic t_out_window;
    read_from(8'h0E, 1'b0, 18, 1, "R5 pointer unchanged by 0x0E");
  endtask

  task automatic t_abort;
    i2c_start();
    for (int i = 7; i >= 4; i--) begin
      m_sda = DEV[i - 1]; wh(); scl = 1'b1; wh(); scl = 1'b0;
    end
    read_from(8'h05, 1'b1, 5, 1, "R11 restart after mid-byte START");
    current_read(6, 1, "R9 R7 pointer after abort path");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 32; a++) begin
      @(negedge clk); ld_we = 1'b1; ld_addr = 5'(a); ld_data = pat(a);
    end
    @(negedge clk); ld_we = 1'b0;
    wh(3);
    t_reset();
    rst_n = 1'b1;
    wh(4);
    t_reset();
    t_first_read();
    t_persist();
    t_wrap_low();
    t_wrap_high();
    t_mismatch();
    t_out_window();
    t_abort();
    check(stab_err == 0, "R6 SDA stable while SCL high", stab_err, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule